// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue Cell Manager

This block manages one common pool of cell slots as a set of linked-list queues. Every queue is identified by an output port, a priority level and a flow group. A cell arrives with those three attributes. It receives the next free slot number, which the surrounding logic uses to address its payload memory, and it is appended to the tail of its queue. When an output link asks for its next cell, the block first picks the most urgent non-empty priority level of that output. It then serves the flow groups queued at that level in rotating order, unlinks the head cell and returns its slot to the pool. In the next cycle it reports the departing slot and emits a single-cell credit that carries the cell's flow group.

The control path takes one event per clock cycle, either an arrival or a departure. Free slots are handed out from an untouched region until that region is used up. After that they come from a stack of returned slots, which is threaded through the same link memory as the queues. No slot is reserved for any port. An arrival that finds the pool exhausted is dropped and flagged. With correct upstream credits this never happens.

Top module: `cellq_mgr`

## Requirements
- R1: After reset every queue is empty, `dep_valid`, `cred_valid` and `ovf_err` are low, and `arr_ready` is high while `dep_req` is low.
- R2: Up to NUM_SLOTS (256) cells can be held at once without an overflow. Each accepted arrival is given a slot number on `arr_slot`, combinationally in its accept cycle, that differs from every slot currently held.
- R3: An arrival that is accepted while all slots are held raises `ovf_err` for exactly one cycle after the accepting edge, and the cell is not stored.
- R4: While `dep_req` is high, `arr_ready` is low and no arrival is taken in that cycle. A departure wins over an arrival requested in the same cycle.
- R5: Priority level 0 is the most urgent. A departure from a port always takes a cell from the lowest-numbered non-empty level of that port.
- R6: Within one port and level, flow groups are served in rotating order. The search starts at the group after the one served last at that port and level, and after reset group 0 is searched first.
- R7: Cells of one port, level and flow group leave in arrival order: the `dep_slot` sequence equals the `arr_slot` sequence.
- R8: One cycle after a departure edge, `dep_valid` and `cred_valid` are high for one cycle. `cred_fg` gives the flow group of the departing cell, `dep_prio` its level and `dep_slot` its slot.
- R9: A departure request for a port that holds no cells yields no departure and no credit, and leaves all queues unchanged.
- R10: Slots freed by departures return to the pool. Once the pool has been drained, another NUM_SLOTS cells fit without an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arr_valid | input | 1 | An arrival is offered this cycle |
| arr_ready | output | 1 | Arrival can be taken (low while a departure is requested) |
| arr_port | input | 5 | Output port of the arriving cell (0..16) |
| arr_prio | input | 2 | Priority level of the arriving cell (0 most urgent) |
| arr_fg | input | 2 | Flow group of the arriving cell |
| arr_slot | output | 8 | Slot number given to the arriving cell |
| dep_req | input | 1 | An output link requests its next cell |
| dep_port | input | 5 | Port making the request |
| dep_valid | output | 1 | A cell left in the previous cycle |
| dep_slot | output | 8 | Slot of the departed cell |
| dep_prio | output | 2 | Priority level of the departed cell |
| cred_valid | output | 1 | Single-cell credit is emitted |
| cred_fg | output | 2 | Flow group carried by the credit |
| ovf_err | output | 1 | An arrival was dropped because the pool was full |

## Verification
An arrival and a departure can be requested in the same cycle. The departure has to win and the arrival has to stall. The bench provokes this by raising `arr_valid` together with `dep_req`, both during the random phase and against ports that are empty. In each case it checks that `arr_ready` is low, that no overflow or phantom cell appears afterwards, and that the later departures still match a model in which the stalled arrival never happened.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  localparam int CQ_NUM_SLOTS = 256;
  localparam int CQ_NUM_OUT   = 17;  // sixteen data outputs plus one management port
  localparam int CQ_NUM_PRIO  = 3;
  localparam int CQ_NUM_FG    = 4;   // flow groups merging per output and level
endpackage

// File: rtl/cellq_link.sv
module cellq_link #(
  parameter int NUM_SLOTS = 256,
  parameter int SW        = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wa,
  input  logic [SW-1:0] wd,
  input  logic [SW-1:0] ra_a,
  output logic [SW-1:0] rd_a,
  input  logic [SW-1:0] ra_b,
  output logic [SW-1:0] rd_b
);
  logic [SW-1:0] mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/cellq_free.sv
module cellq_free #(
  parameter int NUM_SLOTS = 256,
  parameter int SW        = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          rel_en,
  input  logic [SW-1:0] rel_slot,
  input  logic [SW-1:0] link_rd,
  output logic          avail,
  output logic [SW-1:0] slot,
  output logic [SW-1:0] top
);
  logic [SW:0]   fresh_q, fresh_d;
  logic [SW:0]   cnt_q, cnt_d;
  logic [SW-1:0] top_q, top_d;
  logic          fresh_left;

  assign fresh_left = fresh_q < (SW+1)'(NUM_SLOTS);
  assign avail      = fresh_left || (cnt_q != '0);
  assign slot       = fresh_left ? fresh_q[SW-1:0] : top_q;
  assign top        = top_q;

  always_comb begin
    fresh_d = fresh_q;
    cnt_d   = cnt_q;
    top_d   = top_q;
    if (alloc) begin
      if (fresh_left) begin
        fresh_d = fresh_q + 1'b1;
      end else begin
        top_d = link_rd;
        cnt_d = cnt_q - 1'b1;
      end
    end else if (rel_en) begin
      top_d = rel_slot;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= '0;
      cnt_q   <= '0;
      top_q   <= '0;
    end else begin
      fresh_q <= fresh_d;
      cnt_q   <= cnt_d;
      top_q   <= top_d;
    end
  end
endmodule

// File: rtl/cellq_pick.sv
module cellq_pick #(
  parameter int NUM_PRIO = 3,
  parameter int NUM_FG   = 4,
  parameter int PW       = $clog2(NUM_PRIO),
  parameter int FW       = $clog2(NUM_FG)
) (
  input  logic [NUM_PRIO*NUM_FG-1:0] nonempty,
  input  logic [NUM_PRIO*FW-1:0]     last_fg,
  output logic                       found,
  output logic [PW-1:0]              sel_prio,
  output logic [FW-1:0]              sel_fg
);
  always_comb begin
    found    = 1'b0;
    sel_prio = '0;
    sel_fg   = '0;
    for (int pr = 0; pr < NUM_PRIO; pr++) begin
      for (int k = 1; k <= NUM_FG; k++) begin
        automatic int f = (int'(last_fg[pr*FW +: FW]) + k) % NUM_FG;
        if (!found && nonempty[pr*NUM_FG + f]) begin
          found    = 1'b1;
          sel_prio = PW'(pr);
          sel_fg   = FW'(f);
        end
      end
    end
  end
endmodule

// File: rtl/cellq_mgr.sv
module cellq_mgr
  import cellq_pkg::*;
#(
  parameter int NUM_SLOTS = CQ_NUM_SLOTS,
  parameter int NUM_OUT   = CQ_NUM_OUT,
  parameter int NUM_PRIO  = CQ_NUM_PRIO,
  parameter int NUM_FG    = CQ_NUM_FG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arr_valid,
  output logic                          arr_ready,
  input  logic [$clog2(NUM_OUT)-1:0]    arr_port,
  input  logic [$clog2(NUM_PRIO)-1:0]   arr_prio,
  input  logic [$clog2(NUM_FG)-1:0]     arr_fg,
  output logic [$clog2(NUM_SLOTS)-1:0]  arr_slot,
  input  logic                          dep_req,
  input  logic [$clog2(NUM_OUT)-1:0]    dep_port,
  output logic                          dep_valid,
  output logic [$clog2(NUM_SLOTS)-1:0]  dep_slot,
  output logic [$clog2(NUM_PRIO)-1:0]   dep_prio,
  output logic                          cred_valid,
  output logic [$clog2(NUM_FG)-1:0]     cred_fg,
  output logic                          ovf_err
);
  localparam int SW = $clog2(NUM_SLOTS);
  localparam int OW = $clog2(NUM_OUT);
  localparam int PW = $clog2(NUM_PRIO);
  localparam int FW = $clog2(NUM_FG);
  localparam int NQ = NUM_OUT * NUM_PRIO * NUM_FG;
  localparam int QW = $clog2(NQ);
  localparam int NR = NUM_OUT * NUM_PRIO;
  localparam int RW = $clog2(NR);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // queue state
  logic [SW-1:0] head_q [NQ];
  logic [SW-1:0] tail_q [NQ];
  logic [SW:0]   cnt_q  [NQ];
  logic [FW-1:0] rr_q   [NR];

  function automatic logic [QW-1:0] qidx(input int p, input int pr, input int f);
    return QW'((p * NUM_PRIO + pr) * NUM_FG + f);
  endfunction

  // arrival side
  logic          arr_ok, fire, enq, ovf_d, avail;
  logic [QW-1:0] aq;
  logic [SW-1:0] new_slot, free_top, link_a, link_b;

  assign arr_ready = !dep_req;
  assign arr_ok    = (int'(arr_port) < NUM_OUT) && (int'(arr_prio) < NUM_PRIO);
  assign fire      = arr_valid && arr_ready && arr_ok;
  assign enq       = fire && avail;
  assign ovf_d     = fire && !avail;
  assign aq        = qidx(int'(arr_port), int'(arr_prio), int'(arr_fg));
  assign arr_slot  = new_slot;

  // departure side
  logic [NUM_PRIO*NUM_FG-1:0] ne;
  logic [NUM_PRIO*FW-1:0]     rr_vec;
  logic                       dep_ok, found, deq;
  logic [PW-1:0]              sel_pr;
  logic [FW-1:0]              sel_f;
  logic [QW-1:0]              dq;
  logic [RW-1:0]              rq;
  logic [SW-1:0]              dslot;

  assign dep_ok = int'(dep_port) < NUM_OUT;

  always_comb begin
    for (int pr = 0; pr < NUM_PRIO; pr++) begin
      rr_vec[pr*FW +: FW] = dep_ok ? rr_q[RW'(int'(dep_port) * NUM_PRIO + pr)] : '0;
      for (int f = 0; f < NUM_FG; f++) begin
        ne[pr*NUM_FG + f] = dep_ok && (cnt_q[qidx(int'(dep_port), pr, f)] != '0);
      end
    end
  end

  cellq_pick #(.NUM_PRIO(NUM_PRIO), .NUM_FG(NUM_FG)) u_pick (
    .nonempty (ne),
    .last_fg  (rr_vec),
    .found    (found),
    .sel_prio (sel_pr),
    .sel_fg   (sel_f)
  );

  assign deq   = dep_req && found;
  assign dq    = qidx(int'(dep_port), int'(sel_pr), int'(sel_f));
  assign rq    = RW'(int'(dep_port) * NUM_PRIO + int'(sel_pr));
  assign dslot = head_q[dq];

  cellq_free #(.NUM_SLOTS(NUM_SLOTS)) u_free (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .alloc    (enq),
    .rel_en   (deq),
    .rel_slot (dslot),
    .link_rd  (link_a),
    .avail    (avail),
    .slot     (new_slot),
    .top      (free_top)
  );

  // one link write per cycle: a departure pushes onto the free stack,
  // an arrival into a non-empty queue chains behind the old tail
  logic          lk_we;
  logic [SW-1:0] lk_wa, lk_wd;
  always_comb begin
    lk_we = 1'b0;
    lk_wa = '0;
    lk_wd = '0;
    if (deq) begin
      lk_we = 1'b1;
      lk_wa = dslot;
      lk_wd = free_top;
    end else if (enq && (cnt_q[aq] != '0)) begin
      lk_we = 1'b1;
      lk_wa = tail_q[aq];
      lk_wd = new_slot;
    end
  end

  cellq_link #(.NUM_SLOTS(NUM_SLOTS)) u_link (
    .clk  (clk),
    .we   (lk_we),
    .wa   (lk_wa),
    .wd   (lk_wd),
    .ra_a (free_top),
    .rd_a (link_a),
    .ra_b (dslot),
    .rd_b (link_b)
  );

  // pointer registers (no reset needed: guarded by counts)
  always_ff @(posedge clk) begin
    if (enq) begin
      tail_q[aq] <= new_slot;
      if (cnt_q[aq] == '0) head_q[aq] <= new_slot;
    end
    if (deq) head_q[dq] <= link_b;
  end

  // counts and rotation state
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int i = 0; i < NQ; i++) cnt_q[i] <= '0;
      for (int i = 0; i < NR; i++) rr_q[i]  <= FW'(NUM_FG - 1);
    end else begin
      if (enq) cnt_q[aq] <= cnt_q[aq] + 1'b1;
      if (deq) begin
        cnt_q[dq] <= cnt_q[dq] - 1'b1;
        rr_q[rq]  <= sel_f;
      end
    end
  end

  // output registers
  logic          dv_q, ovf_q;
  logic [SW-1:0] ds_q;
  logic [PW-1:0] dp_q;
  logic [FW-1:0] df_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dv_q  <= 1'b0;
      ovf_q <= 1'b0;
      ds_q  <= '0;
      dp_q  <= '0;
      df_q  <= '0;
    end else begin
      dv_q  <= deq;
      ovf_q <= ovf_d;
      if (deq) begin
        ds_q <= dslot;
        dp_q <= sel_pr;
        df_q <= sel_f;
      end
    end
  end

  assign dep_valid  = dv_q;
  assign dep_slot   = ds_q;
  assign dep_prio   = dp_q;
  assign cred_valid = dv_q;
  assign cred_fg    = df_q;
  assign ovf_err    = ovf_q;
endmodule

// File: rtl/cellq_chk.sv
module cellq_chk #(
  parameter int NUM_SLOTS = 256,
  parameter int NUM_OUT   = 17,
  parameter int NUM_PRIO  = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        arr_valid,
  input logic                        arr_ready,
  input logic [$clog2(NUM_OUT)-1:0]  arr_port,
  input logic [$clog2(NUM_PRIO)-1:0] arr_prio,
  input logic                        dep_req,
  input logic                        dep_valid,
  input logic                        cred_valid,
  input logic                        ovf_err
);
  localparam int OCW = $clog2(NUM_SLOTS) + 2;

  logic           take;
  logic [OCW-1:0] occ_q;

  assign take = arr_valid && arr_ready && (int'(arr_port) < NUM_OUT) && (int'(arr_prio) < NUM_PRIO);

  // conservative occupancy seen from the ports
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + OCW'(take) - OCW'(dep_valid) - OCW'(ovf_err);
  end

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dep_req |-> !arr_ready);

  assert_no_ghost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dep_valid |-> $past(dep_req));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(arr_valid && arr_ready));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (occ_q < OCW'(NUM_SLOTS))) |=> !ovf_err);

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cred_valid && ovf_err));
endmodule

bind cellq_mgr cellq_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .NUM_OUT   (NUM_OUT),
  .NUM_PRIO  (NUM_PRIO)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_valid  (arr_valid),
  .arr_ready  (arr_ready),
  .arr_port   (arr_port),
  .arr_prio   (arr_prio),
  .dep_req    (dep_req),
  .dep_valid  (dep_valid),
  .cred_valid (cred_valid),
  .ovf_err    (ovf_err)
);

// File: tb/test_cellq_mgr.sv
`timescale 1ns/1ps
module test_cellq_mgr;
  import cellq_pkg::*;
  localparam int NS = CQ_NUM_SLOTS;
  localparam int NO = CQ_NUM_OUT;
  localparam int NP = CQ_NUM_PRIO;
  localparam int NF = CQ_NUM_FG;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arr_valid = 1'b0, dep_req = 1'b0;
  logic [4:0] arr_port = '0, dep_port = '0;
  logic [1:0] arr_prio = '0, arr_fg = '0;
  logic       arr_ready, dep_valid, cred_valid, ovf_err;
  logic [7:0] arr_slot, dep_slot;
  logic [1:0] dep_prio, cred_fg;

  always #2.5 clk = ~clk;

  cellq_mgr i_cellq_mgr (
    .clk(clk), .rst_n(rst_n),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_port(arr_port),
    .arr_prio(arr_prio), .arr_fg(arr_fg), .arr_slot(arr_slot),
    .dep_req(dep_req), .dep_port(dep_port), .dep_valid(dep_valid),
    .dep_slot(dep_slot), .dep_prio(dep_prio), .cred_valid(cred_valid),
    .cred_fg(cred_fg), .ovf_err(ovf_err)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model
  int unsigned mq [NO][NP][NF][$];
  int          rr [NO][NP];
  bit          in_use [NS];
  int          occ = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_arr(input int p, input int pr, input int f, input bit exp_ovf);
    int s;
    @(negedge clk);
    arr_valid = 1'b1; arr_port = 5'(p); arr_prio = 2'(pr); arr_fg = 2'(f);
    #1;
    chk(arr_ready == 1'b1, "R4", "arr_ready idle", int'(arr_ready), 1);
    s = int'(arr_slot);
    @(negedge clk);
    arr_valid = 1'b0;
    if (exp_ovf) begin
      chk(ovf_err == 1'b1, "R3", "ovf_err on full pool", int'(ovf_err), 1);
    end else begin
      if (ovf_err) chk(1'b0, "R2", "unexpected ovf_err", 1, 0);
      if (in_use[s]) chk(1'b0, "R2", "slot already held", s, -1);
      in_use[s] = 1'b1;
      mq[p][pr][f].push_back(s);
      occ++;
    end
  endtask

  task automatic do_dep(input int p, input bit with_arr);
    bit fnd = 1'b0;
    int epr = 0, ef = 0, es = 0;
    for (int pr = 0; pr < NP; pr++)
      for (int k = 1; k <= NF; k++) begin
        automatic int f = (rr[p][pr] + k) % NF;
        if (!fnd && mq[p][pr][f].size() != 0) begin
          fnd = 1'b1; epr = pr; ef = f;
        end
      end
    if (fnd) begin
      es = int'(mq[p][epr][ef].pop_front());
      rr[p][epr] = ef;
      in_use[es] = 1'b0;
      occ--;
    end
    @(negedge clk);
    dep_req = 1'b1; dep_port = 5'(p);
    arr_valid = with_arr; arr_port = 5'($urandom % NO); arr_prio = 2'($urandom % NP); arr_fg = 2'($urandom % NF);
    #1;
    if (with_arr) chk(arr_ready == 1'b0, "R4", "arr_ready during departure", int'(arr_ready), 0);
    @(negedge clk);
    dep_req = 1'b0; arr_valid = 1'b0;
    chk(dep_valid == fnd, fnd ? "R8" : "R9", "dep_valid", int'(dep_valid), int'(fnd));
    chk(cred_valid == fnd, fnd ? "R8" : "R9", "cred_valid", int'(cred_valid), int'(fnd));
    if (ovf_err) chk(1'b0, "R4", "ovf after stalled arrival", 1, 0);
    if (fnd) begin
      chk(int'(dep_prio) == epr, "R5", "dep_prio", int'(dep_prio), epr);
      chk(int'(cred_fg) == ef, "R6", "cred_fg", int'(cred_fg), ef);
      chk(int'(dep_slot) == es, "R7", "dep_slot", int'(dep_slot), es);
    end
  endtask

  task automatic drain_all();
    for (int p = 0; p < NO; p++) begin
      int n = 0;
      for (int pr = 0; pr < NP; pr++)
        for (int f = 0; f < NF; f++) n += mq[p][pr][f].size();
      for (int i = 0; i < n; i++) do_dep(p, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int p = 0; p < NO; p++)
      for (int pr = 0; pr < NP; pr++) rr[p][pr] = NF - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(dep_valid == 1'b0, "R1", "dep_valid", int'(dep_valid), 0);
    chk(cred_valid == 1'b0, "R1", "cred_valid", int'(cred_valid), 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err", int'(ovf_err), 0);
    chk(arr_ready == 1'b1, "R1", "arr_ready", int'(arr_ready), 1);
    do_dep(3, 1'b0);   // R9: empty port after reset
    do_dep(7, 1'b1);   // R4 collision with empty departure

    // R6: rotation among flow groups, R5: urgent level overtakes
    do_arr(5, 2, 3, 1'b0); do_arr(5, 2, 0, 1'b0);
    do_arr(5, 2, 3, 1'b0); do_arr(5, 2, 1, 1'b0);
    do_dep(5, 1'b0);
    do_arr(5, 0, 2, 1'b0);
    do_dep(5, 1'b1); do_dep(5, 1'b0); do_dep(5, 1'b0); do_dep(5, 1'b0);
    do_dep(5, 1'b0);   // R9: port emptied

    // random mix with collisions
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom % 10;
      automatic int sel = $urandom % 3;
      automatic int p = (sel == 0) ? 0 : (sel == 1) ? 5 : 16;
      if (r < 5 && occ < NS) do_arr(p, $urandom % NP, $urandom % NF, 1'b0);
      else do_dep(p, r >= 8);
    end
    drain_all();

    // R2/R3: fill the whole pool, then one more
    for (int i = 0; i < NS; i++) do_arr(16, 2, 1, 1'b0);
    do_arr(16, 2, 1, 1'b1);
    @(negedge clk);
    chk(ovf_err == 1'b0, "R3", "ovf_err single pulse", int'(ovf_err), 0);
    drain_all();
    do_dep(16, 1'b0);  // R3: dropped cell was not stored

    // R10: pool refilled after drain
    for (int i = 0; i < NS; i++) do_arr(i % NO, i % NP, i % NF, 1'b0);
    chk(occ == NS, "R10", "cells held after refill", occ, NS);
    drain_all();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule